// File: doc/BRIEF.md
# Unsigned Fixed-Point to Floating-Point Converter

This block turns an unsigned fixed-point number into an IEEE-754 binary value of half, single or double precision. The source is 32 or 64 bits wide and carries a programmable count of fraction bits. That count is given indirectly by a 6-bit scale field: the fraction count is 64 minus the scale, and the number converted is the source divided by two to that power. One shared front end finds the leading one and normalises the operand. Three rounding and packing stages, one per precision, then produce the candidate results. The format field picks one of them.

The result is placed in the lowest element of a 128-bit destination word. The bits above the element either keep the old destination contents (merge) or are cleared. Illegal encodings are reported on a dedicated flag and produce no conversion. Inexact, overflow and underflow conditions are reported on their own outputs. All outputs are registered and appear one clock after the inputs.

Top module: `ufix_to_fp`

## Requirements
- R1: With `src_wide_i`=0 only `src_i[31:0]` is converted and `src_i[63:32]` has no effect on any output; with `src_wide_i`=1 all 64 bits are converted. The operand is always unsigned and every non-zero result has sign bit 0.
- R2: `fmt_i` 2'b00 yields single precision in `res_o[31:0]`, 2'b01 double precision in `res_o[63:0]`, and 2'b11 half precision in `res_o[15:0]`.
- R3: The value converted is the operand divided by 2^(64 - `scale_i`), with `scale_i` read as unsigned, so a scale of 0 means 64 fraction bits.
- R4: `fmt_i`=2'b10, or `src_wide_i`=0 together with `scale_i[5]`=0, sets `bad_enc_o`. In that case `res_o` is all zero and the other three flags are clear. Legal encodings clear `bad_enc_o`.
- R5: `rmode_i` selects the rounding: 2'b00 to nearest with ties to even, 2'b01 toward plus infinity, 2'b10 toward minus infinity, 2'b11 toward zero.
- R6: A zero operand gives positive zero with no flag set.
- R7: `inexact_o` is set exactly when the delivered result differs from the exact value.
- R8: A half-precision result whose rounded magnitude exceeds 65504 sets both `overflow_o` and `inexact_o`. It delivers infinity (16'h7C00) under nearest-even and plus-infinity rounding, and the largest finite value (16'h7BFF) otherwise. Single and double precision never overflow or underflow.
- R9: A half-precision value below 2^-14 is delivered as a correctly rounded subnormal or zero. It is tiny when judged before rounding, and `underflow_o` is set when it is tiny and also inexact.
- R10: When `merge_i`=1 the bits of `res_o` above the result element equal the same bits of `old_dst_i`; when `merge_i`=0 they are zero.
- R11: Every output is registered and reflects the inputs present at the previous rising clock edge; while `rst_ni` is low all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Unsigned fixed-point source |
| src_wide_i | input | 1 | 0: 32-bit source, 1: 64-bit source |
| fmt_i | input | 2 | Destination precision select |
| scale_i | input | 6 | Scale field; fraction bits = 64 - scale |
| rmode_i | input | 2 | Rounding mode |
| merge_i | input | 1 | Keep old destination bits above the element |
| old_dst_i | input | 128 | Old destination contents for merge |
| res_o | output | 128 | Destination word, result in the lowest element |
| bad_enc_o | output | 1 | Illegal format or scale encoding |
| inexact_o | output | 1 | Result was rounded |
| overflow_o | output | 1 | Half-precision overflow |
| underflow_o | output | 1 | Tiny and inexact half-precision result |

## Verification
All of the block's results (the destination word and the four flags) come out of one register stage, so each is due at the first rising edge after the inputs settle. The bench drives a stimulus on a falling edge. It then compares the word and the flags on the next falling edge, half a period after the capturing edge and before the next stimulus can change them. The bound properties relate the inputs of one cycle to the outputs of the next with a single-cycle implication, so they follow the same one-cycle timing.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int SRC_W      = 64;
  localparam int DST_W      = 128;
  localparam int SCALE_W    = 6;
  localparam int LZ_W       = $clog2(SRC_W) + 1;
  localparam int EXP_CALC_W = 14;
  localparam int NUM_FMT    = 3;

  // index of each precision in the packing array
  localparam int FI_HP = 0;
  localparam int FI_SP = 1;
  localparam int FI_DP = 2;

  typedef enum logic [1:0] {
    FMT_SP  = 2'b00,
    FMT_DP  = 2'b01,
    FMT_BAD = 2'b10,
    FMT_HP  = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    RM_RNE = 2'b00,
    RM_RUP = 2'b01,
    RM_RDN = 2'b10,
    RM_RTZ = 2'b11
  } rmode_e;

  typedef struct packed {
    logic nx;
    logic of;
    logic uf;
  } cvt_flags_t;

  function automatic int fmt_exp_w(int idx);
    case (idx)
      FI_HP:   return 5;
      FI_SP:   return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_man_w(int idx);
    case (idx)
      FI_HP:   return 10;
      FI_SP:   return 23;
      default: return 52;
    endcase
  endfunction
endpackage

// File: rtl/cvt_lzc.sv
module cvt_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  always_comb begin
    cnt_o = CW'(W);
    // ascending scan: the highest set bit writes last
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end

  assign zero_o = ~|val_i;
endmodule

// File: rtl/cvt_pack.sv
module cvt_pack
  import cvt_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int NORM_W = 64
) (
  input  logic [NORM_W-1:0]           norm_i,
  input  logic signed [EXP_CALC_W-1:0] exp_i,
  input  logic                        zero_i,
  input  logic [1:0]                  rmode_i,
  output logic [EXP_W+MAN_W:0]        bits_o,
  output cvt_flags_t                  flags_o
);
  localparam int KEEP     = MAN_W + 1;
  localparam int WIDE     = 2 * NORM_W;
  localparam int SH_W     = $clog2(WIDE);
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EMIN     = 1 - BIAS;
  localparam int EXP_ALL1 = (1 << EXP_W) - 1;

  logic [SH_W-1:0] dsh;
  logic            tiny;
  logic [WIDE-1:0] aligned;
  logic [KEEP-1:0] kept;
  logic            guard, sticky, rnd_up;
  logic [KEEP:0]   sum;
  int              e_v, diff, be;

  always_comb begin
    e_v  = int'(exp_i);
    diff = EMIN - e_v;
    tiny = diff > 0;
    if (!tiny)             dsh = '0;
    else if (diff >= WIDE) dsh = SH_W'(WIDE - 1);
    else                   dsh = SH_W'(diff);

    // double-width window: denormalising shift loses no bit to sticky
    aligned = {norm_i, {NORM_W{1'b0}}} >> dsh;
    kept    = aligned[WIDE-1 -: KEEP];
    guard   = aligned[WIDE-1-KEEP];
    sticky  = |aligned[WIDE-2-KEEP:0];

    case (rmode_i)
      RM_RNE:  rnd_up = guard & (sticky | kept[0]);
      RM_RUP:  rnd_up = guard | sticky;
      default: rnd_up = 1'b0;
    endcase

    sum = {1'b0, kept} + {{KEEP{1'b0}}, rnd_up};
    be  = tiny ? int'(sum[MAN_W]) : e_v + BIAS + int'(sum[KEEP]);

    bits_o  = '0;
    flags_o = '0;
    if (!zero_i) begin
      if (be >= EXP_ALL1) begin
        flags_o.of = 1'b1;
        flags_o.nx = 1'b1;
        if (rmode_i == RM_RNE || rmode_i == RM_RUP)
          bits_o = {1'b0, EXP_W'(EXP_ALL1), {MAN_W{1'b0}}};
        else
          bits_o = {1'b0, EXP_W'(EXP_ALL1 - 1), {MAN_W{1'b1}}};
      end else begin
        bits_o     = {1'b0, EXP_W'(be), sum[MAN_W-1:0]};
        flags_o.nx = guard | sticky;
        flags_o.uf = tiny & (guard | sticky);
      end
    end
  end
endmodule

// File: rtl/ufix_to_fp.sv
module ufix_to_fp
  import cvt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_W-1:0]   src_i,
  input  logic               src_wide_i,
  input  logic [1:0]         fmt_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [1:0]         rmode_i,
  input  logic               merge_i,
  input  logic [DST_W-1:0]   old_dst_i,
  output logic [DST_W-1:0]   res_o,
  output logic               bad_enc_o,
  output logic               inexact_o,
  output logic               overflow_o,
  output logic               underflow_o
);
  localparam int HALF_W = SRC_W / 2;

  logic [SRC_W-1:0]            operand, norm;
  logic [LZ_W-1:0]             lz;
  logic                        op_zero, bad_enc;
  logic signed [EXP_CALC_W-1:0] exp_unb;
  logic [DST_W-1:0]            base;
  logic [DST_W-1:0]            placed [NUM_FMT];
  cvt_flags_t                  flg    [NUM_FMT];
  logic [DST_W-1:0]            res_d;
  cvt_flags_t                  flg_d;

  assign operand = src_wide_i ? src_i : {{HALF_W{1'b0}}, src_i[HALF_W-1:0]};
  assign bad_enc = (fmt_i == FMT_BAD) || (!src_wide_i && !scale_i[SCALE_W-1]);

  cvt_lzc #(.W(SRC_W), .CW(LZ_W)) u_lzc (
    .val_i  (operand),
    .cnt_o  (lz),
    .zero_o (op_zero)
  );

  assign norm = operand << lz[LZ_W-2:0];
  // msb weight = (SRC_W-1-lz) - (64-scale) = scale - lz - 1
  assign exp_unb = EXP_CALC_W'(scale_i) - EXP_CALC_W'(lz) - EXP_CALC_W'(1);
  assign base    = merge_i ? old_dst_i : '0;

  for (genvar gi = 0; gi < NUM_FMT; gi++) begin : g_fmt
    localparam int EW = fmt_exp_w(gi);
    localparam int MW = fmt_man_w(gi);
    localparam int FW = 1 + EW + MW;
    logic [FW-1:0] bits;

    cvt_pack #(.EXP_W(EW), .MAN_W(MW), .NORM_W(SRC_W)) u_pack (
      .norm_i  (norm),
      .exp_i   (exp_unb),
      .zero_i  (op_zero),
      .rmode_i (rmode_i),
      .bits_o  (bits),
      .flags_o (flg[gi])
    );

    assign placed[gi] = {base[DST_W-1:FW], bits};
  end

  always_comb begin
    res_d = '0;
    flg_d = '0;
    if (!bad_enc) begin
      case (fmt_i)
        FMT_HP: begin res_d = placed[FI_HP]; flg_d = flg[FI_HP]; end
        FMT_SP: begin res_d = placed[FI_SP]; flg_d = flg[FI_SP]; end
        default: begin res_d = placed[FI_DP]; flg_d = flg[FI_DP]; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      bad_enc_o   <= 1'b0;
      inexact_o   <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      res_o       <= res_d;
      bad_enc_o   <= bad_enc;
      inexact_o   <= flg_d.nx;
      overflow_o  <= flg_d.of;
      underflow_o <= flg_d.uf;
    end
  end
endmodule

// File: rtl/ufix_to_fp_chk.sv
module ufix_to_fp_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [63:0]  src_i,
  input logic         src_wide_i,
  input logic [1:0]   fmt_i,
  input logic         scale_top_i,
  input logic         merge_i,
  input logic [95:0]  old_hi_i,
  input logic [127:0] res_o,
  input logic         bad_enc_o,
  input logic         inexact_o,
  input logic         overflow_o,
  input logic         underflow_o
);
  logic legal, op_zero;
  assign legal   = (fmt_i != 2'b10) && (src_wide_i || scale_top_i);
  assign op_zero = src_wide_i ? (src_i == '0) : (src_i[31:0] == '0);

  assert_bad_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_enc_o |-> (res_o == '0 && !inexact_o && !overflow_o && !underflow_o));

  assert_bad_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal |=> bad_enc_o);

  assert_good_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal |=> !bad_enc_o);

  assert_ovf_inexact_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> inexact_o);

  assert_unf_inexact_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> inexact_o);

  assert_wide_fmt_no_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i != 2'b11) |=> (!overflow_o && !underflow_o));

  assert_zero_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal && op_zero) |=> (res_o[15:0] == '0 && !inexact_o && !overflow_o));

  assert_merge_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal && merge_i && fmt_i == 2'b00) |=> (res_o[127:32] == $past(old_hi_i)));

  assert_merge_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal && !merge_i && fmt_i == 2'b11) |=> (res_o[127:16] == '0));
endmodule

bind ufix_to_fp ufix_to_fp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .src_wide_i  (src_wide_i),
  .fmt_i       (fmt_i),
  .scale_top_i (scale_i[5]),
  .merge_i     (merge_i),
  .old_hi_i    (old_dst_i[127:32]),
  .res_o       (res_o),
  .bad_enc_o   (bad_enc_o),
  .inexact_o   (inexact_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/ufix_to_fp_bench.sv
module ufix_to_fp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  typedef struct packed {
    logic        wide;
    logic [1:0]  fmt;
    logic [5:0]  scale;
    logic [1:0]  rm;
    logic [63:0] src;
    logic [63:0] exp;
    logic        nx, of, uf, bad;
    logic [3:0]  rq;
  } vec_t;

  // wide fmt scale rm src expected nx of uf bad req
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 6'd63, 2'd0, 64'hDEAD_BEEF_0000_0002, 64'h3F80_0000, 1'b0,1'b0,1'b0,1'b0, 4'd1},  // R1
    '{1'b1, 2'b00, 6'd63, 2'd0, 64'h0000_0001_0000_0000, 64'h4F00_0000, 1'b0,1'b0,1'b0,1'b0, 4'd1},  // R1
    '{1'b1, 2'b01, 6'd0,  2'd0, 64'h8000_0000_0000_0000, 64'h3FE0_0000_0000_0000, 1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2
    '{1'b0, 2'b11, 6'd63, 2'd0, 64'h3, 64'h3E00, 1'b0,1'b0,1'b0,1'b0, 4'd2},                           // R2
    '{1'b1, 2'b01, 6'd0,  2'd0, 64'h1, 64'h3BF0_0000_0000_0000, 1'b0,1'b0,1'b0,1'b0, 4'd3},            // R3
    '{1'b0, 2'b00, 6'd32, 2'd0, 64'h8000_0000, 64'h3F00_0000, 1'b0,1'b0,1'b0,1'b0, 4'd3},              // R3
    '{1'b1, 2'b10, 6'd63, 2'd0, 64'h5, 64'h0, 1'b0,1'b0,1'b0,1'b1, 4'd4},                              // R4
    '{1'b0, 2'b00, 6'd31, 2'd0, 64'h5, 64'h0, 1'b0,1'b0,1'b0,1'b1, 4'd4},                              // R4
    '{1'b0, 2'b11, 6'd0,  2'd1, 64'h7, 64'h0, 1'b0,1'b0,1'b0,1'b1, 4'd4},                              // R4
    '{1'b1, 2'b00, 6'd63, 2'd0, 64'h200_0002, 64'h4B80_0000, 1'b1,1'b0,1'b0,1'b0, 4'd5},               // R5
    '{1'b1, 2'b00, 6'd63, 2'd1, 64'h200_0002, 64'h4B80_0001, 1'b1,1'b0,1'b0,1'b0, 4'd5},               // R5
    '{1'b0, 2'b00, 6'd32, 2'd2, 64'hFFFF_FFFF, 64'h3F7F_FFFF, 1'b1,1'b0,1'b0,1'b0, 4'd5},              // R5
    '{1'b0, 2'b00, 6'd32, 2'd0, 64'hFFFF_FFFF, 64'h3F80_0000, 1'b1,1'b0,1'b0,1'b0, 4'd5},              // R5
    '{1'b1, 2'b01, 6'd63, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h43DF_FFFF_FFFF_FFFF, 1'b1,1'b0,1'b0,1'b0, 4'd5}, // R5
    '{1'b1, 2'b00, 6'd10, 2'd1, 64'h0, 64'h0, 1'b0,1'b0,1'b0,1'b0, 4'd6},                              // R6
    '{1'b1, 2'b01, 6'd63, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h43E0_0000_0000_0000, 1'b1,1'b0,1'b0,1'b0, 4'd7}, // R7
    '{1'b0, 2'b11, 6'd63, 2'd0, 64'h2_0000, 64'h7C00, 1'b1,1'b1,1'b0,1'b0, 4'd8},                      // R8
    '{1'b0, 2'b11, 6'd63, 2'd3, 64'h2_0000, 64'h7BFF, 1'b1,1'b1,1'b0,1'b0, 4'd8},                      // R8
    '{1'b0, 2'b11, 6'd63, 2'd2, 64'h2_0000, 64'h7BFF, 1'b1,1'b1,1'b0,1'b0, 4'd8},                      // R8
    '{1'b0, 2'b11, 6'd63, 2'd3, 64'h1_FFFE, 64'h7BFF, 1'b1,1'b0,1'b0,1'b0, 4'd8},                      // R8
    '{1'b1, 2'b11, 6'd40, 2'd0, 64'h1, 64'h0001, 1'b0,1'b0,1'b0,1'b0, 4'd9},                           // R9
    '{1'b1, 2'b11, 6'd39, 2'd0, 64'h1, 64'h0000, 1'b1,1'b0,1'b1,1'b0, 4'd9},                           // R9
    '{1'b1, 2'b11, 6'd39, 2'd1, 64'h1, 64'h0001, 1'b1,1'b0,1'b1,1'b0, 4'd9},                           // R9
    '{1'b1, 2'b11, 6'd38, 2'd0, 64'h3, 64'h0001, 1'b1,1'b0,1'b1,1'b0, 4'd9}                            // R9
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [63:0]  src = '0;
  logic         wide = 1'b0;
  logic [1:0]   fmt = '0;
  logic [5:0]   scale = '0;
  logic [1:0]   rm = '0;
  logic         merge = 1'b0;
  logic [127:0] old = '0;
  logic [127:0] res;
  logic         bad, nx, of, uf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ufix_to_fp u_ufix_to_fp (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .src_wide_i(wide), .fmt_i(fmt),
    .scale_i(scale), .rmode_i(rm), .merge_i(merge), .old_dst_i(old),
    .res_o(res), .bad_enc_o(bad), .inexact_o(nx), .overflow_o(of), .underflow_o(uf)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on a falling edge; registered result is valid by the next falling edge
  task automatic apply(input logic w, input logic [1:0] f, input logic [5:0] s,
                       input logic [1:0] r, input logic [63:0] v, input logic m);
    @(negedge clk);
    wide = w; fmt = f; scale = s; rm = r; src = v; merge = m;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    old = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    wide = 1'b1; fmt = 2'b11; scale = 6'd63; src = 64'h2_0000; merge = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset holds every output at zero
    check("R11 reset result", res, '0);
    check("R11 reset flags", {124'b0, bad, nx, of, uf}, '0);
    rst_n = 1'b1;
    merge = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].wide, VECS[i].fmt, VECS[i].scale, VECS[i].rm, VECS[i].src, 1'b0);
      check($sformatf("R%0d vec %0d result", VECS[i].rq, i), res, {64'b0, VECS[i].exp});
      check($sformatf("R%0d vec %0d flags", VECS[i].rq, i), {124'b0, bad, nx, of, uf},
            {124'b0, VECS[i].bad, VECS[i].nx, VECS[i].of, VECS[i].uf});
    end

    // R10: merge keeps bits above the element
    apply(1'b0, 2'b00, 6'd63, 2'd0, 64'h2, 1'b1);
    check("R10 merge single", res, {old[127:32], 32'h3F80_0000});
    apply(1'b0, 2'b11, 6'd63, 2'd0, 64'h3, 1'b1);
    check("R10 merge half", res, {old[127:16], 16'h3E00});
    apply(1'b1, 2'b01, 6'd0, 2'd0, 64'h8000_0000_0000_0000, 1'b1);
    check("R10 merge double", res, {old[127:64], 64'h3FE0_0000_0000_0000});
    // R4: illegal encoding clears the word even with merge on
    apply(1'b1, 2'b10, 6'd63, 2'd0, 64'h3, 1'b1);
    check("R4 bad with merge", res, '0);
    check("R4 bad flag with merge", {127'b0, bad}, 128'd1);

    // R11: result follows a new input after exactly one edge
    @(negedge clk);
    wide = 1'b0; fmt = 2'b00; scale = 6'd63; src = 64'h2; merge = 1'b0;
    #1;
    check("R11 old value before edge", {127'b0, bad}, 128'd1);
    @(negedge clk);
    check("R11 new value after edge", res, {96'b0, 32'h3F80_0000});

    // R3 R5 R7: double precision, nearest-even, against real arithmetic
    for (int i = 0; i < 16; i++) begin
      logic [63:0] op;
      logic [5:0]  sc;
      real         rv;
      op = (64'h9E37_79B9_7F4A_7C15 * 64'(i + 1)) >> (i % 40);
      op[63] = 1'b0;
      sc = 6'((i * 7 + 3) % 64);
      rv = real'(op) / (2.0 ** real'(64 - int'(sc)));
      apply(1'b1, 2'b01, sc, 2'd0, op, 1'b0);
      check($sformatf("R3 R5 double model %0d", i), res, {64'b0, $realtobits(rv)});
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule